// File: doc/BRIEF.md
# Programmable Priority Round-Robin Arbiter

This block makes one fair choice among a set of requesters in a single cycle, the kind of decision a crossbar scheduler repeats at every output (grant) and every input (accept). Each cycle it looks at an N-bit request vector and a stored priority pointer. It returns a one-hot grant, the binary index of the winner and a valid flag, all combinationally.

The priority search runs two plain lowest-index encoders side by side. One sees only the requests at or above the pointer, through a thermometer mask built from the pointer. The other sees every request and ignores the pointer. When the masked encoder finds a request, its answer is used (path PATH_MASKED). When it finds none but the unmasked encoder does, the search has wrapped past the top and the unmasked answer is used (path PATH_FALLBACK). With no request at all the path is PATH_IDLE.

The pointer is the only stored state. It advances to one past the winner only when the update-enable input is high in a cycle that has a winner. This lets the surrounding scheduler move the pointer only for decisions it actually commits. Each cycle the pointer either stays (HOLD) or moves (ADVANCE).

Top module: `prr_arbiter`

## Requirements
- R1: `grant` has at most one bit set, that bit is also set in `req`, and `grant_idx` is its binary position (bit i set gives index i).
- R2: With `req` all zeros, `grant` is zero and `grant_vld` is low, and `ptr` keeps its value on the next clock edge even with `upd_en` high.
- R3: When any request at an index greater than or equal to `ptr` is set, the winner is the lowest such index.
- R4: When no request at or above `ptr` is set but some request is set, the winner is the lowest set index overall.
- R5: On a clock edge with `upd_en` high and `grant_vld` high, `ptr` becomes `grant_idx + 1`, wrapping from N-1 to 0.
- R6: On a clock edge with `upd_en` low, `ptr` keeps its value even when a grant is issued.
- R7: A synchronous active-high `rst` sets `ptr` to 0 on the clock edge.
- R8: With all requests held high and `upd_en` held high, the winner index steps 0, 1, ..., N-1 and then wraps to 0, one step per cycle.
- R9: `grant`, `grant_idx` and `grant_vld` follow a change of `req` in the same cycle, with no clock edge between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_REQ | Request vector, bit i from requester i |
| upd_en | input | 1 | Allows the pointer to advance after this cycle's decision |
| grant | output | NUM_REQ | One-hot grant, zero when no request |
| grant_idx | output | IDX_W | Binary index of the granted requester |
| grant_vld | output | 1 | High when some request is granted |
| ptr | output | IDX_W | Current priority pointer |

## Verification
The bench places the pointer at every position and then applies all request patterns with updates held off, so it covers the boundary where a request sits exactly at the pointer, the case where all requests lie below the pointer, and the empty vector. A design with an off-by-one mask would skip the request at the pointer or grant one just below it. A design with a broken fallback would return no grant when the search has to wrap. It also checks that the pointer holds when updates are off, that it holds when there is no winner, that it wraps from the top index to zero, and that all-ones requests rotate in strict order. A design that advanced from the old pointer instead of from the winner, or ignored the enable, would break one of these.

// File: rtl/prr_pkg.sv
package prr_pkg;

    // Which encoder supplied this cycle's decision
    typedef enum logic [1:0] {
        PATH_IDLE     = 2'd0,
        PATH_MASKED   = 2'd1,
        PATH_FALLBACK = 2'd2
    } arb_path_e;

    // Pointer register action for the coming edge
    typedef enum logic {
        PTR_HOLD    = 1'b0,
        PTR_ADVANCE = 1'b1
    } ptr_act_e;

endpackage

// File: rtl/prr_thermo_mask.sv
module prr_thermo_mask #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic [IDX_W-1:0]   level,
    output logic [NUM_REQ-1:0] mask
);

    // Bit g is kept when g is at or above the priority level
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_bit
        assign mask[g] = (32'(g) >= 32'(level));
    end

endmodule

// File: rtl/prr_simple_pe.sv
module prr_simple_pe #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // Lowest set bit wins: scan from the top so lower bits overwrite
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prr_ptr_reg.sv
module prr_ptr_reg
    import prr_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  ptr_act_e         act,
    input  logic [IDX_W-1:0] win_idx,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_REQ - 1);

    logic [IDX_W-1:0] ptr_next;

    always_comb begin
        unique case (act)
            PTR_ADVANCE: ptr_next = (win_idx == TOP_IDX) ? '0 : win_idx + IDX_W'(1);
            PTR_HOLD:    ptr_next = ptr;
            default:     ptr_next = ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else     ptr <= ptr_next;
    end

endmodule

// File: rtl/prr_arbiter.sv
module prr_arbiter
    import prr_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    input  logic               upd_en,
    output logic [NUM_REQ-1:0] grant,
    output logic [IDX_W-1:0]   grant_idx,
    output logic               grant_vld,
    output logic [IDX_W-1:0]   ptr
);

    logic [NUM_REQ-1:0] therm;
    logic [NUM_REQ-1:0] req_hi;
    logic               hit_hi;
    logic               hit_any;
    logic [IDX_W-1:0]   idx_hi;
    logic [IDX_W-1:0]   idx_any;
    arb_path_e          path;
    ptr_act_e           act;

    prr_thermo_mask #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_mask (
        .level (ptr),
        .mask  (therm)
    );

    assign req_hi = req & therm;

    prr_simple_pe #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pe_masked (
        .vec   (req_hi),
        .found (hit_hi),
        .idx   (idx_hi)
    );

    prr_simple_pe #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pe_raw (
        .vec   (req),
        .found (hit_any),
        .idx   (idx_any)
    );

    // Path selection
    always_comb begin
        if (hit_hi)       path = PATH_MASKED;
        else if (hit_any) path = PATH_FALLBACK;
        else              path = PATH_IDLE;
    end

    // Outputs per path
    always_comb begin
        unique case (path)
            PATH_MASKED: begin
                grant_vld = 1'b1;
                grant_idx = idx_hi;
            end
            PATH_FALLBACK: begin
                grant_vld = 1'b1;
                grant_idx = idx_any;
            end
            default: begin
                grant_vld = 1'b0;
                grant_idx = '0;
            end
        endcase
        grant = grant_vld ? (NUM_REQ'(1) << grant_idx) : '0;
        act   = (grant_vld && upd_en) ? PTR_ADVANCE : PTR_HOLD;
    end

    prr_ptr_reg #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .win_idx (grant_idx),
        .ptr     (ptr)
    );

endmodule

// File: rtl/prr_arbiter_chk.sv
module prr_arbiter_chk #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req,
    input logic               upd_en,
    input logic [NUM_REQ-1:0] grant,
    input logic [IDX_W-1:0]   grant_idx,
    input logic               grant_vld,
    input logic [IDX_W-1:0]   ptr
);

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req) == '0));

    // R1
    grant_idx_match_chk: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> grant[grant_idx]);

    // R2
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> (!grant_vld && grant == '0));

    // R2
    idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |=> $stable(ptr));

    // R3
    masked_first_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && grant_idx < ptr) |-> ((req >> ptr) == '0));

    // R4
    fallback_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_vld && grant_idx < ptr) |-> ((req & ((NUM_REQ'(1) << grant_idx) - NUM_REQ'(1))) == '0));

    // R5
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_en && grant_vld) |=>
            (ptr == (($past(grant_idx) == IDX_W'(NUM_REQ - 1)) ? '0 : $past(grant_idx) + IDX_W'(1))));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(ptr));

    // R7
    reset_ptr_chk: assert property (@(posedge clk)
        rst |=> (ptr == '0));

endmodule

bind prr_arbiter prr_arbiter_chk #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .upd_en    (upd_en),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_vld (grant_vld),
    .ptr       (ptr)
);

// File: tb/sim_prr_arbiter.sv
`timescale 1ns/1ps
module sim_prr_arbiter;

    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req;
    logic          upd_en;
    logic [N-1:0]  grant;
    logic [IW-1:0] grant_idx;
    logic          grant_vld;
    logic [IW-1:0] ptr;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    prr_arbiter #(.NUM_REQ(N)) u0 (
        .clk(clk), .rst(rst), .req(req), .upd_en(upd_en),
        .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld), .ptr(ptr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Expected winner from the requirements: first set bit at or above p, else lowest
    function automatic int exp_win(input logic [N-1:0] r, input int p);
        for (int i = p; i < N; i++) if (r[i]) return i;
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    task automatic check_outputs(input logic [N-1:0] r, input int p);
        int w;
        string tag;
        w = exp_win(r, p);
        if (w < 0) begin
            chk(grant_vld == 1'b0, "R2 vld", int'(grant_vld), 0);
            chk(grant == '0, "R2 grant", int'(grant), 0);
        end else begin
            tag = (w >= p) ? "R3/R9 idx" : "R4/R9 idx";
            chk(grant_vld == 1'b1, "R1 vld", int'(grant_vld), 1);
            chk(int'(grant_idx) == w, tag, int'(grant_idx), w);
            chk(grant == (N'(1) << w), "R1 grant", int'(grant), 1 << w);
        end
    endtask

    // Move the pointer to p by granting requester p-1 with updates on
    task automatic set_ptr(input int p);
        @(negedge clk);
        req    = N'(1) << ((p + N - 1) % N);
        upd_en = 1'b1;
        @(negedge clk);
        req    = '0;
        upd_en = 1'b0;
        #1;
        chk(int'(ptr) == p, "R5 advance", int'(ptr), p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst    = 1'b1;
        req    = '0;
        upd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(ptr == '0, "R7 reset ptr", int'(ptr), 0);
        chk(grant == '0 && !grant_vld, "R2 reset outputs", int'(grant), 0);

        // Exhaustive sweep: every pointer, every request pattern, updates off
        for (int p = 0; p < N; p++) begin
            set_ptr(p);
            for (int r = 0; r < (1 << N); r++) begin
                @(negedge clk);
                req    = N'(r);
                upd_en = 1'b0;
                #1;
                chk(int'(ptr) == p, "R6 hold", int'(ptr), p);
                check_outputs(N'(r), p);
            end
            @(negedge clk);
            req = '0;
            #1;
            chk(int'(ptr) == p, "R6 hold after grant", int'(ptr), p);
        end

        // Empty request with updates on: pointer stays
        set_ptr(5);
        @(negedge clk);
        req    = '0;
        upd_en = 1'b1;
        @(negedge clk);
        #1;
        chk(int'(ptr) == 5, "R2 ptr idle", int'(ptr), 5);

        // Wrap from the top index to zero, advancing from the winner not the pointer
        @(negedge clk);
        req    = N'(1) << (N - 1);
        upd_en = 1'b1;
        @(negedge clk);
        #1;
        chk(int'(ptr) == 0, "R5 wrap", int'(ptr), 0);
        req = N'(8'b0000_0100);
        @(negedge clk);
        #1;
        chk(int'(ptr) == 3, "R5 from winner", int'(ptr), 3);
        req    = '0;
        upd_en = 1'b0;

        // Reset mid-run
        set_ptr(6);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(ptr == '0, "R7 reset mid-run", int'(ptr), 0);

        // Strict rotation with all requests high
        @(negedge clk);
        req    = '1;
        upd_en = 1'b1;
        for (int k = 0; k < 2 * N; k++) begin
            #1;
            chk(int'(grant_idx) == (k % N), "R8 rotation", int'(grant_idx), k % N);
            @(negedge clk);
        end
        req    = '0;
        upd_en = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule